// File: doc/BRIEF.md
# Reset Request Combiner with Cause Register

This block gathers every reset request of a processor subsystem into one active-high system reset. The requests are power-on, brown-out, the external reset pin, the software reset instruction, watchdog expiry, hard-trap conflict, illegal-condition detection and configuration mismatch. The analog detectors, the pin glitch filter, the trap arbitration and the watchdog counter all sit outside this block. Each one hands over a request that is already clean and synchronous.

Alongside the reset path, the block keeps a 16-bit cause and status register. Start-up code reads it to learn why the last reset happened. Software can write it at any time to set or clear any implemented bit, and a write never causes a reset. Sleep entry, idle entry and watchdog-clear events also update the register. Each flag has its own set of reset types that clear it.

A watchdog expiry while the core is in a low-power mode wakes the core instead of resetting it. A power-on or brown-out reset is reported as cold. Every other source is reported as warm.

Top module: `reset_gather`

## Requirements
- R1: While any of `por_req`, `bor_req`, `pin_req`, `trap_conflict`, `illegal_req` or `cfg_mismatch` is high, `sys_rst` is high in that same cycle.
- R2: Register layout: bit 15 trap conflict, bit 14 illegal condition, bit 9 configuration mismatch, bit 8 regulator standby control, bit 7 external pin, bit 6 software reset, bit 5 software watchdog enable, bit 4 watchdog expiry, bit 3 sleep, bit 2 idle, bit 1 brown-out, bit 0 power-on. Bits 13 to 10 always read 0 and ignore writes, so writing all ones reads back 0xC3FF.
- R3: A cycle with `por_req` high loads 0x0003 at that clock edge, whatever else is active in that cycle.
- R4: Without power-on, `bor_req` sets bit 1 and clears bits 15, 14, 9, 8, 6, 5, 4, 3 and 2. Bits 7 and 0 keep their values.
- R5: `sleep_enter`, `idle_enter` or `wdt_clear` clears bit 4. Sleep entry also sets bit 3, and idle entry also sets bit 2.
- R6: Each request sets its own flag at the clock edge that samples it. Pin sets bit 7, trap sets bit 15, illegal sets bit 14, mismatch sets bit 9, software sets bit 6, watchdog expiry sets bit 4 in any mode, and brown-out sets bit 1.
- R7: A write (`reg_we` high) loads `reg_wdata` into the implemented bits at the next edge. A write never drives `sys_rst`.
- R8: When several updates hit the same bit in one cycle, a hardware set beats a hardware clear, and a hardware clear beats a software write.
- R9: A `swi_req` cycle with no power-on request drives `sys_rst` high in exactly the following cycle. A request in a power-on cycle produces no pulse.
- R10: `wdt_expire` with `low_power` high drives `wdt_wake` and does not reset. With `low_power` low it drives `sys_rst` high in the same cycle and `wdt_wake` stays low.
- R11: `cold_rst` is high exactly while `por_req` or `bor_req` is high. It stays low for all other sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_req | input | 1 | Power-on reset request |
| bor_req | input | 1 | Brown-out reset request |
| pin_req | input | 1 | Filtered external reset pin request |
| swi_req | input | 1 | Software reset instruction executed |
| wdt_expire | input | 1 | Watchdog time-out |
| trap_conflict | input | 1 | Hard-trap conflict detected |
| illegal_req | input | 1 | Illegal opcode, uninitialized pointer or protection violation |
| cfg_mismatch | input | 1 | Shadowed configuration mismatch |
| low_power | input | 1 | Core is in sleep or idle |
| sleep_enter | input | 1 | Sleep entry event |
| idle_enter | input | 1 | Idle entry event |
| wdt_clear | input | 1 | Watchdog clear event |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| sys_rst | output | 1 | Combined system reset, active high |
| cold_rst | output | 1 | Current reset is cold |
| wdt_wake | output | 1 | Watchdog wake from low power |

## Verification
The bench builds the block with the default 16-bit register, the only layout the bit map allows. At that width, every bit can be covered. Writing all ones and then all zeros reaches every implemented bit and the four dead bits. A random mix of rare requests, events and writes reaches the per-bit priority cases: a set against a write, a clear against a write, and a set against a clear. Directed cases cover power-on combined with other requests, brown-out preserving the pin flag, and the one-cycle software pulse.

// File: rtl/reset_gather_pkg.sv
package reset_gather_pkg;
  localparam int REG_W = 16;

  // Bit positions of the cause/status register
  localparam int B_TRAP = 15;
  localparam int B_ILL  = 14;
  localparam int B_CM   = 9;
  localparam int B_VREG = 8;
  localparam int B_PIN  = 7;
  localparam int B_SW   = 6;
  localparam int B_WEN  = 5;
  localparam int B_WDT  = 4;
  localparam int B_SLP  = 3;
  localparam int B_IDL  = 2;
  localparam int B_BOR  = 1;
  localparam int B_POR  = 0;

  function automatic logic [REG_W-1:0] bit_at(input int pos);
    return REG_W'(1) << pos;
  endfunction

  localparam logic [REG_W-1:0] IMPL_MASK =
    bit_at(B_TRAP) | bit_at(B_ILL) | bit_at(B_CM) | bit_at(B_VREG) |
    bit_at(B_PIN)  | bit_at(B_SW)  | bit_at(B_WEN) | bit_at(B_WDT) |
    bit_at(B_SLP)  | bit_at(B_IDL) | bit_at(B_BOR) | bit_at(B_POR);

  localparam logic [REG_W-1:0] POR_VALUE = bit_at(B_BOR) | bit_at(B_POR);

  // Bits a brown-out leaves alone (bit 1 is set by it instead)
  localparam logic [REG_W-1:0] BOR_KEEP = bit_at(B_PIN) | bit_at(B_BOR) | bit_at(B_POR);

  // One flag bit: hardware set > hardware clear > software write > hold
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic hw_clr, input logic we,
                                     input logic wd);
    return hw_set | (~hw_clr & (we ? wd : cur));
  endfunction
endpackage

// File: rtl/rg_source_merge.sv
module rg_source_merge (
  input  logic clk,
  input  logic por_req,
  input  logic bor_req,
  input  logic pin_req,
  input  logic swi_req,
  input  logic wdt_expire,
  input  logic trap_conflict,
  input  logic illegal_req,
  input  logic cfg_mismatch,
  input  logic low_power,
  output logic sys_rst,
  output logic cold_rst,
  output logic wdt_wake,
  output logic sw_hold
);
  logic wdt_run_rst;

  // Software reset lasts one cycle after the instruction is seen
  always_ff @(posedge clk) begin
    sw_hold <= swi_req & ~por_req;
  end

  assign wdt_run_rst = wdt_expire & ~low_power;
  assign wdt_wake    = wdt_expire & low_power;
  assign cold_rst    = por_req | bor_req;
  assign sys_rst     = cold_rst | pin_req | trap_conflict | illegal_req |
                       cfg_mismatch | wdt_run_rst | sw_hold;
endmodule

// File: rtl/rg_event_map.sv
module rg_event_map
  import reset_gather_pkg::*;
(
  input  logic             por_req,
  input  logic             bor_req,
  input  logic             pin_req,
  input  logic             swi_req,
  input  logic             wdt_expire,
  input  logic             trap_conflict,
  input  logic             illegal_req,
  input  logic             cfg_mismatch,
  input  logic             sleep_enter,
  input  logic             idle_enter,
  input  logic             wdt_clear,
  output logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] clr_vec
);
  always_comb begin
    set_vec          = '0;
    set_vec[B_TRAP]  = trap_conflict;
    set_vec[B_ILL]   = illegal_req;
    set_vec[B_CM]    = cfg_mismatch;
    set_vec[B_PIN]   = pin_req;
    set_vec[B_SW]    = swi_req;
    set_vec[B_WDT]   = wdt_expire;
    set_vec[B_SLP]   = sleep_enter;
    set_vec[B_IDL]   = idle_enter;
    set_vec[B_BOR]   = bor_req | por_req;
    set_vec[B_POR]   = por_req;
  end

  always_comb begin
    clr_vec        = bor_req ? (IMPL_MASK & ~BOR_KEEP) : '0;
    clr_vec[B_WDT] = clr_vec[B_WDT] | sleep_enter | idle_enter | wdt_clear;
  end
endmodule

// File: rtl/rg_flag_bank.sv
module rg_flag_bank
  import reset_gather_pkg::*;
(
  input  logic             clk,
  input  logic             por_req,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] flags
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (por_req) q <= POR_VALUE[i];
        else         q <= flag_next(q, set_vec[i], clr_vec[i], wr_en, wr_data[i]);
      end
      assign flags[i] = q;
    end else begin : g_dead
      logic unused_in;
      assign unused_in = ^{set_vec[i], clr_vec[i], wr_data[i]};
      assign flags[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/reset_gather.sv
module reset_gather
  import reset_gather_pkg::*;
(
  input  logic             clk,
  input  logic             por_req,
  input  logic             bor_req,
  input  logic             pin_req,
  input  logic             swi_req,
  input  logic             wdt_expire,
  input  logic             trap_conflict,
  input  logic             illegal_req,
  input  logic             cfg_mismatch,
  input  logic             low_power,
  input  logic             sleep_enter,
  input  logic             idle_enter,
  input  logic             wdt_clear,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sys_rst,
  output logic             cold_rst,
  output logic             wdt_wake
);
  logic             sw_hold;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;

  rg_source_merge u_merge (
    .clk           (clk),
    .por_req       (por_req),
    .bor_req       (bor_req),
    .pin_req       (pin_req),
    .swi_req       (swi_req),
    .wdt_expire    (wdt_expire),
    .trap_conflict (trap_conflict),
    .illegal_req   (illegal_req),
    .cfg_mismatch  (cfg_mismatch),
    .low_power     (low_power),
    .sys_rst       (sys_rst),
    .cold_rst      (cold_rst),
    .wdt_wake      (wdt_wake),
    .sw_hold       (sw_hold)
  );

  rg_event_map u_map (
    .por_req       (por_req),
    .bor_req       (bor_req),
    .pin_req       (pin_req),
    .swi_req       (swi_req),
    .wdt_expire    (wdt_expire),
    .trap_conflict (trap_conflict),
    .illegal_req   (illegal_req),
    .cfg_mismatch  (cfg_mismatch),
    .sleep_enter   (sleep_enter),
    .idle_enter    (idle_enter),
    .wdt_clear     (wdt_clear),
    .set_vec       (set_vec),
    .clr_vec       (clr_vec)
  );

  rg_flag_bank u_bank (
    .clk     (clk),
    .por_req (por_req),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .wr_en   (reg_we),
    .wr_data (reg_wdata),
    .flags   (reg_rdata)
  );
endmodule

// File: rtl/reset_gather_chk.sv
module reset_gather_chk (
  input logic        clk,
  input logic        por_req,
  input logic        bor_req,
  input logic        pin_req,
  input logic        swi_req,
  input logic        wdt_expire,
  input logic        trap_conflict,
  input logic        illegal_req,
  input logic        cfg_mismatch,
  input logic        low_power,
  input logic        wdt_clear,
  input logic        reg_we,
  input logic [15:0] reg_rdata,
  input logic        sys_rst,
  input logic        cold_rst,
  input logic        wdt_wake,
  input logic        sw_hold
);
  logic armed;
  logic hard_req;
  initial armed = 1'b0;
  always @(posedge clk) armed <= armed | por_req;

  assign hard_req = por_req | bor_req | pin_req | trap_conflict | illegal_req | cfg_mismatch;

  p_req_drives_rst_r1: assert property (@(posedge clk) disable iff (!armed)
    hard_req |-> sys_rst);
  p_dead_bits_zero_r2: assert property (@(posedge clk) disable iff (!armed)
    por_req |=> reg_rdata[13:10] == 4'd0);
  p_por_value_r3: assert property (@(posedge clk) disable iff (!armed)
    por_req |=> reg_rdata == 16'h0003);
  p_bor_keeps_pin_r4: assert property (@(posedge clk) disable iff (!armed)
    (bor_req && !por_req && !pin_req && !reg_we) |=> reg_rdata[7] == $past(reg_rdata[7]));
  p_wdt_clear_r5: assert property (@(posedge clk) disable iff (!armed)
    (wdt_clear && !wdt_expire && !por_req) |=> !reg_rdata[4]);
  p_write_no_rst_r7: assert property (@(posedge clk) disable iff (!armed)
    (reg_we && !hard_req && !sw_hold && !wdt_expire && !swi_req) |-> !sys_rst);
  p_set_beats_write_r8: assert property (@(posedge clk) disable iff (!armed)
    (trap_conflict && reg_we && !por_req) |=> reg_rdata[15]);
  p_sw_pulse_r9: assert property (@(posedge clk) disable iff (!armed)
    (swi_req && !por_req) |=> (sys_rst && reg_rdata[6]));
  p_sw_release_r9: assert property (@(posedge clk) disable iff (!armed)
    !swi_req |=> !sw_hold);
  p_wake_no_rst_r10: assert property (@(posedge clk) disable iff (!armed)
    (wdt_expire && low_power && !hard_req && !sw_hold) |-> (wdt_wake && !sys_rst));
  p_wdt_run_rst_r10: assert property (@(posedge clk) disable iff (!armed)
    (wdt_expire && !low_power) |-> (sys_rst && !wdt_wake));
  p_cold_implies_rst_r11: assert property (@(posedge clk) disable iff (!armed)
    cold_rst |-> sys_rst);
endmodule

bind reset_gather reset_gather_chk u_chk (
  .clk           (clk),
  .por_req       (por_req),
  .bor_req       (bor_req),
  .pin_req       (pin_req),
  .swi_req       (swi_req),
  .wdt_expire    (wdt_expire),
  .trap_conflict (trap_conflict),
  .illegal_req   (illegal_req),
  .cfg_mismatch  (cfg_mismatch),
  .low_power     (low_power),
  .wdt_clear     (wdt_clear),
  .reg_we        (reg_we),
  .reg_rdata     (reg_rdata),
  .sys_rst       (sys_rst),
  .cold_rst      (cold_rst),
  .wdt_wake      (wdt_wake),
  .sw_hold       (sw_hold)
);

// File: tb/reset_gather_bench.sv
module reset_gather_bench;
  logic        clk = 1'b0;
  logic        por_req = 0, bor_req = 0, pin_req = 0, swi_req = 0, wdt_expire = 0;
  logic        trap_conflict = 0, illegal_req = 0, cfg_mismatch = 0, low_power = 0;
  logic        sleep_enter = 0, idle_enter = 0, wdt_clear = 0, reg_we = 0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sys_rst, cold_rst, wdt_wake;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_reg = 16'h0;
  logic        sw_prev = 1'b0;

  always #2 clk = ~clk;

  reset_gather u_reset_gather (
    .clk(clk), .por_req(por_req), .bor_req(bor_req), .pin_req(pin_req),
    .swi_req(swi_req), .wdt_expire(wdt_expire), .trap_conflict(trap_conflict),
    .illegal_req(illegal_req), .cfg_mismatch(cfg_mismatch), .low_power(low_power),
    .sleep_enter(sleep_enter), .idle_enter(idle_enter), .wdt_clear(wdt_clear),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst(sys_rst), .cold_rst(cold_rst), .wdt_wake(wdt_wake)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Requirement-level model of the next register value
  function automatic logic [15:0] model_next(input logic [15:0] cur);
    logic [15:0] r;
    if (por_req) return 16'h0003;
    for (int i = 0; i < 16; i++) begin
      logic s, c;
      case (i)
        15: s = trap_conflict;
        14: s = illegal_req;
        9:  s = cfg_mismatch;
        7:  s = pin_req;
        6:  s = swi_req;
        4:  s = wdt_expire;
        3:  s = sleep_enter;
        2:  s = idle_enter;
        1:  s = bor_req;
        default: s = 1'b0;
      endcase
      c = (bor_req && i != 7 && i != 1 && i != 0) ||
          (i == 4 && (sleep_enter || idle_enter || wdt_clear));
      if (i >= 10 && i <= 13) r[i] = 1'b0;
      else if (s)             r[i] = 1'b1;
      else if (c)             r[i] = 1'b0;
      else if (reg_we)        r[i] = reg_wdata[i];
      else                    r[i] = cur[i];
    end
    return r;
  endfunction

  task automatic clear_inputs();
    por_req = 0; bor_req = 0; pin_req = 0; swi_req = 0; wdt_expire = 0;
    trap_conflict = 0; illegal_req = 0; cfg_mismatch = 0; low_power = 0;
    sleep_enter = 0; idle_enter = 0; wdt_clear = 0; reg_we = 0; reg_wdata = 16'h0;
  endtask

  // Called at a falling edge with inputs already applied
  task automatic tick(input string tag);
    logic [15:0] nxt;
    logic        sw_n;
    logic        e_rst;
    #1;
    e_rst = por_req | bor_req | pin_req | trap_conflict | illegal_req |
            cfg_mismatch | (wdt_expire & ~low_power) | sw_prev;
    check(tag, "sys_rst", {15'd0, sys_rst}, {15'd0, e_rst});
    check(tag, "cold_rst", {15'd0, cold_rst}, {15'd0, por_req | bor_req});
    check(tag, "wdt_wake", {15'd0, wdt_wake}, {15'd0, wdt_expire & low_power});
    nxt  = model_next(exp_reg);
    sw_n = swi_req & ~por_req;
    @(posedge clk);
    @(negedge clk);
    exp_reg = nxt;
    sw_prev = sw_n;
    check(tag, "reg_rdata", reg_rdata, exp_reg);
    clear_inputs();
  endtask

  task automatic write_reg(input logic [15:0] v);
    reg_we = 1; reg_wdata = v; tick("R7");
  endtask

  initial begin
    @(negedge clk);
    // R3: power-on value, also when combined with other requests
    por_req = 1; tick("R3");
    check("R3", "por value", reg_rdata, 16'h0003);
    por_req = 1; trap_conflict = 1; reg_we = 1; reg_wdata = 16'hFFFF; tick("R3");
    check("R3", "por dominates", reg_rdata, 16'h0003);
    // R2: layout and dead bits
    write_reg(16'hFFFF);
    check("R2", "all ones", reg_rdata, 16'hC3FF);
    write_reg(16'h0000);
    check("R7", "all zeros", reg_rdata, 16'h0000);
    // R4: brown-out keeps pin and power-on flags
    write_reg(16'hFFFF);
    bor_req = 1; tick("R4");
    check("R4", "bor from ones", reg_rdata, 16'h0083);
    write_reg(16'h0000);
    bor_req = 1; tick("R4");
    check("R4", "bor from zero", reg_rdata, 16'h0002);
    // R5: watchdog flag clears
    write_reg(16'h0010); wdt_clear = 1; tick("R5");
    check("R5", "wdt clear", reg_rdata, 16'h0000);
    write_reg(16'h0010); sleep_enter = 1; tick("R5");
    check("R5", "sleep entry", reg_rdata, 16'h0008);
    write_reg(16'h0010); idle_enter = 1; tick("R5");
    check("R5", "idle entry", reg_rdata, 16'h0004);
    // R6: each source sets its flag
    write_reg(16'h0000); pin_req = 1; tick("R6");
    check("R6", "pin flag", reg_rdata, 16'h0080);
    write_reg(16'h0000); trap_conflict = 1; illegal_req = 1; cfg_mismatch = 1; tick("R6");
    check("R6", "trap/illegal/mismatch", reg_rdata, 16'hC200);
    // R8: priority
    write_reg(16'h0000); trap_conflict = 1; reg_we = 1; reg_wdata = 16'h0000; tick("R8");
    check("R8", "set beats write", reg_rdata, 16'h8000);
    wdt_expire = 1; wdt_clear = 1; tick("R8");
    check("R8", "set beats clear", reg_rdata[4:4], 1'b1);
    bor_req = 1; reg_we = 1; reg_wdata = 16'hFFFF; tick("R8");
    check("R8", "clear beats write", reg_rdata, 16'h0083);
    // R9: one-cycle software reset
    write_reg(16'h0000);
    swi_req = 1; tick("R9");
    check("R9", "sw flag", reg_rdata, 16'h0040);
    tick("R9");
    tick("R9");
    // R10: watchdog in low power and in run mode
    low_power = 1; wdt_expire = 1; tick("R10");
    wdt_expire = 1; tick("R10");
    // R11: cold versus warm
    bor_req = 1; tick("R11");
    pin_req = 1; tick("R11");
    illegal_req = 1; tick("R11");
    // Constrained random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      por_req       = ($urandom % 64) == 0;
      bor_req       = ($urandom % 24) == 0;
      pin_req       = ($urandom % 16) == 0;
      swi_req       = ($urandom % 12) == 0;
      wdt_expire    = ($urandom % 12) == 0;
      trap_conflict = ($urandom % 16) == 0;
      illegal_req   = ($urandom % 16) == 0;
      cfg_mismatch  = ($urandom % 16) == 0;
      low_power     = ($urandom % 3) == 0;
      sleep_enter   = ($urandom % 10) == 0;
      idle_enter    = ($urandom % 10) == 0;
      wdt_clear     = ($urandom % 8) == 0;
      reg_we        = ($urandom % 4) == 0;
      reg_wdata     = 16'($urandom);
      tick("R1");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule